// File: doc/BRIEF.md
# Host Register Port with Command and Read-Back FIFOs

This block is the host-facing register port of a graphics controller. A host reaches it through two locations chosen by a register-select line. With select low, a write loads a pointer register and a read returns a live status word. With select high, the access goes to the register that the pointer names. Pointer value zero is a queue port: writes there feed an eight-word command queue, and reads there drain an eight-word read-back queue. Pointer value two is the command control register.

A downstream command consumer takes words from the command queue over a valid/ready pair, one word per cycle. The drawing side returns results into the read-back queue with a push strobe. The block drives an interrupt request from status flags masked by enables in the control register. When command DMA is enabled it also drives a cycle-stealing DMA request. Acknowledged DMA words always land in the command queue, wherever the pointer points.

Top module: `hrf_host_port`

## Requirements
- R1: A write with select low loads the pointer register from the low ADDR_W data bits, and a read with select low returns the status word.
- R2: After reset the status word reads 16'hFF23 (queues empty, engine idle), the control register reads 16'h8000, the pointer is 0, both queues are empty and the last-read value is 0. Reset discards any queued words.
- R3: Status bit 0 is set when the command queue is empty. Bit 1 is set when the command queue has room for a word. Bit 2 is set when the read-back queue holds a word. Bit 3 is set when the read-back queue is full. Bit 5 follows eng_idle. Bits 15:8 read as one, and bits 4, 6 and 7 read as zero.
- R4: A write with select high and pointer 0 appends the data word to the command queue, and the consumer receives the words in write order on cmd_data.
- R5: The command queue holds 8 words. A write while it is full is dropped and leaves the queued words intact.
- R6: A read with select high and pointer 0 returns the oldest read-back word and removes it. With the queue empty it returns the last word read and removes nothing. The read-back queue holds 8 words and drops pushes while full.
- R7: The control register is read and written with select high at pointer 2. Any other non-zero pointer reads 0, and writes to it change nothing.
- R8: While control bit 15 (halt) is set, cmd_valid stays low. Otherwise the consumer removes one word in every cycle where cmd_valid and cmd_ready are both high.
- R9: irq is high exactly when some status bit in positions 7:0 is set together with the control bit at the same position.
- R10: dma_req is high when control bit 11 is set and the command queue is empty. A cycle with dma_ack high appends bus_wdata to the command queue whatever the pointer holds.
- R11: A dma_done pulse clears control bit 11, so dma_req is low from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Host access strobe, one access per cycle |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_rs | input | 1 | Register select: 0 = status/pointer, 1 = pointed register |
| bus_wdata | input | DATA_W | Host write data, also DMA data |
| bus_rdata | output | DATA_W | Host read data, valid in the access cycle |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | Command DMA request |
| dma_ack | input | 1 | DMA write strobe into the command queue |
| dma_done | input | 1 | Ends command DMA |
| cmd_valid | output | 1 | Command queue head is available |
| cmd_data | output | DATA_W | Command queue head |
| cmd_ready | input | 1 | Consumer takes the head |
| rd_push | input | 1 | Drawing side pushes a read-back word |
| rd_push_data | input | DATA_W | Read-back word |
| eng_idle | input | 1 | Drawing side idle, shown in status |

## Verification
The embedded properties check several things on every cycle. A push into a full queue and a pop from an empty queue must leave the occupancy unchanged. A consumer handshake must lower the command count by exactly one. A select-low write must land in the pointer. A DMA acknowledge must leave the command queue non-empty. A done pulse must drop the DMA request. Only the bench scenarios can show the rest: word ordering through both queues, the exact status encoding, the held last value on an empty read, the interrupt masking per bit, the reset values, and the discarding of queued words by reset.

// File: rtl/hrf_pkg.sv
package hrf_pkg;
   // status bit positions (software decodes these)
   localparam int unsigned ST_WF_EMPTY = 0;
   localparam int unsigned ST_WF_ROOM  = 1;
   localparam int unsigned ST_RF_AVAIL = 2;
   localparam int unsigned ST_RF_FULL  = 3;
   localparam int unsigned ST_ENG_IDLE = 5;
   // control register bit positions
   localparam int unsigned CC_DMA      = 11;
   localparam int unsigned CC_HALT     = 15;
   localparam int unsigned IRQ_SRC     = 8;
endpackage

// File: rtl/hrf_fifo.sv
module hrf_fifo #(
   parameter int unsigned W     = 16,
   parameter int unsigned DEPTH = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [W-1:0]               push_data,
   input  logic                       pop,
   output logic [W-1:0]               head,
   output logic                       empty,
   output logic                       full,
   output logic [$clog2(DEPTH+1)-1:0] count
);
   localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH+1);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp, wp_inc, rp_inc;
   logic [CW-1:0] cnt;
   logic          acc_push, acc_pop;

   assign full     = (cnt == CW'(DEPTH));
   assign empty    = (cnt == '0);
   assign acc_push = push && !full;
   assign acc_pop  = pop && !empty;
   assign head     = mem[rp];
   assign count    = cnt;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
         assign wp_inc = wp + PW'(1);
         assign rp_inc = rp + PW'(1);
      end else begin : g_wrap_cmp
         assign wp_inc = (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
         assign rp_inc = (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (acc_push) mem[wp] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (acc_push) wp <= wp_inc;
         if (acc_pop)  rp <= rp_inc;
         case ({acc_push, acc_pop})
            2'b10:   cnt <= cnt + CW'(1);
            2'b01:   cnt <= cnt - CW'(1);
            default: cnt <= cnt;
         endcase
      end
   end

   // R5
   full_push_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> (cnt == $past(cnt)));

   // R6
   empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/hrf_status.sv
module hrf_status import hrf_pkg::*; #(
   parameter int unsigned W = 16
) (
   input  logic                wf_empty,
   input  logic                wf_full,
   input  logic                rf_empty,
   input  logic                rf_full,
   input  logic                eng_idle,
   input  logic [IRQ_SRC-1:0]  irq_en,
   output logic [W-1:0]        status,
   output logic                irq
);
   always_comb begin
      status                  = '0;
      status[W-1:IRQ_SRC]     = '1;
      status[ST_WF_EMPTY]     = wf_empty;
      status[ST_WF_ROOM]      = !wf_full;
      status[ST_RF_AVAIL]     = !rf_empty;
      status[ST_RF_FULL]      = rf_full;
      status[ST_ENG_IDLE]     = eng_idle;
   end

   assign irq = |(status[IRQ_SRC-1:0] & irq_en);
endmodule

// File: rtl/hrf_host_port.sv
module hrf_host_port import hrf_pkg::*; #(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned FIFO_BYTES = 16,
   parameter int unsigned CCR_ADDR   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_cs,
   input  logic              bus_rnw,
   input  logic              bus_rs,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   output logic              dma_req,
   input  logic              dma_ack,
   input  logic              dma_done,
   output logic              cmd_valid,
   output logic [DATA_W-1:0] cmd_data,
   input  logic              cmd_ready,
   input  logic              rd_push,
   input  logic [DATA_W-1:0] rd_push_data,
   input  logic              eng_idle
);
   localparam int unsigned DEPTH = FIFO_BYTES / (DATA_W / 8);
   localparam int unsigned CW    = $clog2(DEPTH + 1);

   logic [ADDR_W-1:0] ar;
   logic [DATA_W-1:0] ccr, status, rf_head, last_rd;
   logic [CW-1:0]     wf_count, rf_count;
   logic host_wr, host_rd, win_fifo, win_ccr;
   logic wf_push, wf_pop, wf_empty, wf_full;
   logic rf_pop, rf_empty, rf_full;

   assign host_wr  = bus_cs && !bus_rnw;
   assign host_rd  = bus_cs && bus_rnw;
   assign win_fifo = bus_rs && (ar == '0);
   assign win_ccr  = bus_rs && (ar == ADDR_W'(CCR_ADDR));
   assign wf_push  = dma_ack || (host_wr && win_fifo);
   assign wf_pop   = cmd_ready && !ccr[CC_HALT];
   assign rf_pop   = host_rd && win_fifo;

   hrf_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_cmd_q (
      .clk(clk), .rst_n(rst_n), .push(wf_push), .push_data(bus_wdata),
      .pop(wf_pop), .head(cmd_data), .empty(wf_empty), .full(wf_full),
      .count(wf_count));

   hrf_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rd_q (
      .clk(clk), .rst_n(rst_n), .push(rd_push), .push_data(rd_push_data),
      .pop(rf_pop), .head(rf_head), .empty(rf_empty), .full(rf_full),
      .count(rf_count));

   hrf_status #(.W(DATA_W)) u_status (
      .wf_empty(wf_empty), .wf_full(wf_full), .rf_empty(rf_empty),
      .rf_full(rf_full), .eng_idle(eng_idle), .irq_en(ccr[IRQ_SRC-1:0]),
      .status(status), .irq(irq));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ar           <= '0;
         ccr          <= '0;
         ccr[CC_HALT] <= 1'b1;
         last_rd      <= '0;
      end else begin
         if (host_wr && !bus_rs)          ar <= bus_wdata[ADDR_W-1:0];
         if (host_wr && win_ccr)          ccr <= bus_wdata;
         if (dma_done)                    ccr[CC_DMA] <= 1'b0;
         if (rf_pop && !rf_empty)         last_rd <= rf_head;
      end
   end

   always_comb begin
      if (!bus_rs)       bus_rdata = status;
      else if (win_fifo) bus_rdata = rf_empty ? last_rd : rf_head;
      else if (win_ccr)  bus_rdata = ccr;
      else               bus_rdata = '0;
   end

   assign cmd_valid = !wf_empty && !ccr[CC_HALT];
   assign dma_req   = ccr[CC_DMA] && wf_empty;

   // R1
   ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && !bus_rs) |=> (ar == $past(bus_wdata[ADDR_W-1:0])));

   // R8
   cmd_pop_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && !wf_push) |=> (wf_count == $past(wf_count) - CW'(1)));

   // R6
   rd_pop_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_pop && !rf_empty && !rd_push) |=> (rf_count == $past(rf_count) - CW'(1)));

   // R10
   dma_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_ack && !wf_full) |=> !wf_empty);

   // R11
   dma_done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_done |=> !dma_req);
endmodule

// File: tb/hrf_host_port_tb.sv
`timescale 1ns/1ps
module hrf_host_port_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 0, rnw = 0, rs = 0, dma_ack = 0, dma_done = 0;
   logic cmd_ready = 0, rd_push = 0, eng_idle = 1;
   logic [15:0] wdata = '0, rd_push_data = '0;
   logic [15:0] rdata, cmd_data;
   logic irq, dma_req, cmd_valid;

   int n_checks = 0;
   int n_err    = 0;
   logic [15:0] wq[$];
   logic [15:0] rq[$];
   logic [15:0] last_model = '0;

   always #10 clk = ~clk;

   hrf_host_port u_dut (
      .clk(clk), .rst_n(rst_n), .bus_cs(cs), .bus_rnw(rnw), .bus_rs(rs),
      .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq), .dma_req(dma_req),
      .dma_ack(dma_ack), .dma_done(dma_done), .cmd_valid(cmd_valid),
      .cmd_data(cmd_data), .cmd_ready(cmd_ready), .rd_push(rd_push),
      .rd_push_data(rd_push_data), .eng_idle(eng_idle));

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_status(input int wn, input int rn, input logic idle);
      logic [15:0] s;
      s = 16'hFF00;
      s[0] = (wn == 0);
      s[1] = (wn < 8);
      s[2] = (rn > 0);
      s[3] = (rn == 8);
      s[5] = idle;
      return s;
   endfunction

   function automatic logic [15:0] exp_rd();
      if (rq.size() > 0) last_model = rq.pop_front();
      return last_model;
   endfunction

   task automatic wr(input logic r, input logic [15:0] d);
      @(negedge clk); cs = 1; rnw = 0; rs = r; wdata = d;
      @(posedge clk); #1 cs = 0;
   endtask

   task automatic rd(input logic r, output logic [15:0] v);
      @(negedge clk); cs = 1; rnw = 1; rs = r;
      #2 v = rdata;
      @(posedge clk); #1 cs = 0;
   endtask

   task automatic host_q_write(input logic [15:0] d);
      wr(1, d);
      if (wq.size() < 8) wq.push_back(d);
   endtask

   task automatic eng_push(input logic [15:0] d);
      @(negedge clk); rd_push = 1; rd_push_data = d;
      @(posedge clk); #1 rd_push = 0;
      if (rq.size() < 8) rq.push_back(d);
   endtask

   task automatic consume_one();
      @(negedge clk); cmd_ready = 1;
      #1;
      check("R8 valid", {15'd0, cmd_valid}, {15'd0, wq.size() > 0});
      if (wq.size() > 0) check("R4 order", cmd_data, wq.pop_front());
      @(posedge clk); #1 cmd_ready = 0;
   endtask

   initial begin
      logic [15:0] v;
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      // reset state
      rd(0, v); check("R2 status reset", v, 16'hFF23);
      check("R2 irq", {15'd0, irq}, 16'd0);
      check("R2 dma_req", {15'd0, dma_req}, 16'd0);
      check("R2 cmd_valid", {15'd0, cmd_valid}, 16'd0);
      rd(1, v); check("R2 pointer 0 reads last 0", v, 16'h0000);
      wr(0, 16'h0002);
      rd(1, v); check("R2 R7 control reset", v, 16'h8000);
      rd(0, v); check("R1 status via select low", v, 16'hFF23);

      // halted fill, overflow
      wr(0, 16'h0000);
      for (int i = 0; i < 3; i++) host_q_write(16'hA000 + 16'(i));
      #1 check("R8 halt holds valid low", {15'd0, cmd_valid}, 16'd0);
      rd(0, v); check("R3 status 3 queued", v, exp_status(3, 0, 1));
      for (int i = 3; i < 10; i++) host_q_write(16'hA000 + 16'(i));
      rd(0, v); check("R5 R3 status full", v, exp_status(8, 0, 1));

      // release halt, consume back-to-back
      wr(0, 16'h0002); wr(1, 16'h0000); wr(0, 16'h0000);
      @(negedge clk); cmd_ready = 1;
      for (int i = 0; i < 8; i++) begin
         #1;
         check("R8 valid per cycle", {15'd0, cmd_valid}, 16'd1);
         check("R4 R5 order", cmd_data, wq.pop_front());
         @(negedge clk);
      end
      #1 check("R5 overflow words dropped", {15'd0, cmd_valid}, 16'd0);
      cmd_ready = 0;

      // directed read-back queue full and empty
      for (int i = 0; i < 9; i++) eng_push(16'hB000 + 16'(i));
      rd(0, v); check("R6 R3 read queue full", v, exp_status(0, 8, 1));
      for (int i = 0; i < 9; i++) begin
         logic [15:0] e;
         e = exp_rd();
         rd(1, v); check("R6 read-back", v, e);
      end
      check("R6 empty holds last", v, 16'hB007);

      // random mix
      for (int i = 0; i < 300; i++) begin
         int op;
         logic [15:0] e;
         op = int'($urandom % 5);
         case (op)
            0: host_q_write(16'($urandom));
            1: consume_one();
            2: eng_push(16'($urandom));
            3: begin e = exp_rd(); rd(1, v); check("R6 random read", v, e); end
            default: begin rd(0, v); check("R3 random status", v, exp_status(wq.size(), rq.size(), 1)); end
         endcase
      end

      // drain
      while (wq.size() > 0) consume_one();
      while (rq.size() > 0) begin
         logic [15:0] e;
         e = exp_rd(); rd(1, v); check("R6 drain", v, e);
      end
      eng_idle = 0;
      rd(0, v); check("R3 idle bit low", v, exp_status(0, 0, 0));
      eng_idle = 1;

      // interrupt masking
      wr(0, 16'h0002); wr(1, 16'h0001);
      #1 check("R9 irq on queue empty", {15'd0, irq}, 16'd1);
      wr(0, 16'h0000); host_q_write(16'h0055);
      #1 check("R9 irq clears", {15'd0, irq}, 16'd0);
      wr(0, 16'h0002); wr(1, 16'h0004);
      #1 check("R9 masked source off", {15'd0, irq}, 16'd0);
      eng_push(16'h0077);
      #1 check("R9 irq on read-back data", {15'd0, irq}, 16'd1);
      wr(0, 16'h0000);
      begin logic [15:0] e; e = exp_rd(); rd(1, v); check("R6 read 77", v, e); end
      #1 check("R9 irq drops", {15'd0, irq}, 16'd0);
      consume_one();

      // unmapped address
      wr(0, 16'h0010); wr(1, 16'h1234);
      rd(1, v); check("R7 unmapped reads zero", v, 16'h0000);
      wr(0, 16'h0002);
      rd(1, v); check("R7 control untouched", v, 16'h0004);
      rd(0, v); check("R7 queues untouched", v, exp_status(0, 0, 1));

      // command DMA
      wr(1, 16'h0800);
      #1 check("R10 dma_req when empty", {15'd0, dma_req}, 16'd1);
      wr(0, 16'h0010);
      @(negedge clk); dma_ack = 1; wdata = 16'hBEEF;
      @(posedge clk); #1 dma_ack = 0;
      wq.push_back(16'hBEEF);
      check("R10 dma_req drops", {15'd0, dma_req}, 16'd0);
      check("R10 dma word queued", cmd_data, 16'hBEEF);
      consume_one();
      #1 check("R10 dma_req again", {15'd0, dma_req}, 16'd1);
      @(negedge clk); dma_done = 1;
      @(posedge clk); #1 dma_done = 0;
      check("R11 done clears request", {15'd0, dma_req}, 16'd0);
      wr(0, 16'h0002);
      rd(1, v); check("R11 dma bit cleared", v, 16'h0000);

      // reset discards queued words
      wr(0, 16'h0000);
      host_q_write(16'h1111); host_q_write(16'h2222);
      eng_push(16'h3333);
      @(negedge clk); rst_n = 0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1;
      wq.delete(); rq.delete(); last_model = '0;
      rd(0, v); check("R2 status after reset", v, 16'hFF23);
      check("R2 queue cleared", {15'd0, cmd_valid}, 16'd0);
      rd(1, v); check("R2 read-back cleared", v, 16'h0000);

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

   initial begin
      #2000000;
      n_checks++; n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end
endmodule